// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word addresses for a four-beat burst on a synchronous burst memory. A load strobe captures a full starting address and a beat-ordering choice. Each later advance strobe moves the burst to its next beat.

Only the two low-order address bits change during a burst. They follow one of two orders:

- **Linear:** a wrapping count upward from the start value.
- **Interleaved:** the start value XOR-ed with the beat number.

All higher address bits come from the captured start address and do not change during the burst. The block also drives the current beat number and a flag for the final beat. After the fourth beat, one more advance brings the burst back to its starting address.

The block has no data stream. Every pin is a plain control or status pin, so there is no valid/ready handshake and no back-pressure: a strobe acts in the cycle in which it is sampled high. Outputs come straight from registered state, so they change one clock edge after the strobe that causes the change.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the beat number, the captured address and the captured order all clear to zero, with order value 0 meaning linear. After such an edge, `burst_addr_o` is 0, `beat_o` is 0 and `last_o` is 0.
- R2: When `load_i` is high at an edge, `start_addr_i` is captured. After that edge, `burst_addr_o` equals the captured address and `beat_o` is 0.
- R3: With linear order captured (`mode_i` = 0 at load), bits [1:0] of `burst_addr_o` equal (captured bits [1:0] + `beat_o`) modulo 4. For example, a start of 01 gives 01, 10, 11, 00.
- R4: With interleaved order captured (`mode_i` = 1 at load), bits [1:0] of `burst_addr_o` equal captured bits [1:0] XOR `beat_o`. For example, a start of 01 gives 01, 00, 11, 10, and a start of 11 gives 11, 10, 01, 00.
- R5: Bits above [1:0] of `burst_addr_o` equal the captured address. They ignore `start_addr_i` in any cycle without a load.
- R6: An edge with `adv_i` high and `load_i` low raises `beat_o` by one, modulo 4. The fifth beat therefore presents the starting address again.
- R7: An edge with both `adv_i` and `load_i` low leaves `burst_addr_o` and `beat_o` unchanged.
- R8: When `load_i` and `adv_i` are both high at one edge, the load wins, and `beat_o` becomes 0.
- R9: `mode_i` is sampled only on a load edge. A change of `mode_i` between loads has no effect on the address order.
- R10: `last_o` is high exactly while `beat_o` equals 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture start address and order, restart at beat 0 |
| adv_i | input | 1 | Step to the next beat |
| mode_i | input | 1 | Order select at load: 0 linear, 1 interleaved |
| start_addr_i | input | ADDR_W | Burst starting address |
| burst_addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Current beat number, 0 to 3 |
| last_o | output | 1 | High on the final beat |

## Verification
The assertions assume the following about the inputs:

- Reset is held high for at least one rising edge before any strobe matters.
- `load_i`, `adv_i` and `mode_i` carry known 0 or 1 values at every edge.

The stimulus meets both assumptions. It holds reset for several cycles first. After that it drives every input to a defined value on each falling edge, choosing directed values or values drawn from a fixed-seed `$urandom` stream. Loads, advances, simultaneous strobes, idle cycles and mode changes between loads are all mixed, so the priority and hold paths are exercised as well as the two orders.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEATS  = 4;
  localparam int BEAT_W = $clog2(BEATS);

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [ADDR_W-1:0] start_q,
  output order_e            order_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      order_q <= ORD_LINEAR;
    end else if (load_i) begin
      start_q <= start_addr_i;
      order_q <= order_e'(mode_i);
    end
  end

  AST_START_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    load_i |=> start_q == $past(start_addr_i)); // R2

  AST_START_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(start_q)); // R5

  AST_ORDER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(order_q)); // R9

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load_i,
  input  logic  adv_i,
  output beat_t beat_q,
  output logic  last_o
);

  localparam beat_t LAST_BEAT = beat_t'(BEATS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
    end else if (load_i) begin
      beat_q <= '0;
    end else if (adv_i) begin
      beat_q <= beat_q + beat_t'(1);
    end
  end

  assign last_o = (beat_q == LAST_BEAT);

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    load_i |=> beat_q == '0); // R8

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_i) |=> beat_q == beat_t'($past(beat_q) + beat_t'(1))); // R6

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_i) |=> $stable(beat_q)); // R7

  AST_LAST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (last_o && adv_i && !load_i) |=> (beat_q == '0 && !last_o)); // R10

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
(
  input  beat_t  base_i,
  input  beat_t  beat_i,
  input  order_e order_i,
  output beat_t  low_o
);

  beat_t lin_sum;
  beat_t xor_sum;
  logic [BEAT_W:0] carry;

  assign carry[0] = 1'b0;

  for (genvar g = 0; g < BEAT_W; g++) begin : g_bit
    assign lin_sum[g]  = base_i[g] ^ beat_i[g] ^ carry[g];
    assign carry[g+1]  = (base_i[g] & beat_i[g]) | (carry[g] & (base_i[g] ^ beat_i[g]));
    assign xor_sum[g]  = base_i[g] ^ beat_i[g];
  end

  always_comb begin
    unique case (order_i)
      ORD_XOR:    low_o = xor_sum;
      default:    low_o = lin_sum;
    endcase
  end

  always_comb begin
    if (beat_i == '0) begin
      AST_FIRST_BEAT_BASE: assert (low_o == base_i); // R2
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [ADDR_W-1:0] burst_addr_o,
  output logic [1:0]        beat_o,
  output logic              last_o
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] start_q;
  order_e            order_q;
  beat_t             beat_q;
  beat_t             low_addr;

  burst_start_reg #(.ADDR_W(ADDR_W)) i_start (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load_i),
    .mode_i       (mode_i),
    .start_addr_i (start_addr_i),
    .start_q      (start_q),
    .order_q      (order_q)
  );

  burst_beat_ctr i_ctr (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_i),
    .adv_i  (adv_i),
    .beat_q (beat_q),
    .last_o (last_o)
  );

  burst_order_map i_map (
    .base_i  (start_q[BEAT_W-1:0]),
    .beat_i  (beat_q),
    .order_i (order_q),
    .low_o   (low_addr)
  );

  assign burst_addr_o = {start_q[ADDR_W-1:BEAT_W], low_addr};
  assign beat_o       = beat_q;

  AST_UPPER_STEADY: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(burst_addr_o[ADDR_W-1:BEAT_W])); // R5

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_i) |=> $stable(burst_addr_o)); // R7

  AST_HI_WIDTH: assert property (@(posedge clk) HI_W > 0); // R5

endmodule

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              load_i = 1'b0;
  logic              adv_i = 1'b0;
  logic              mode_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic [ADDR_W-1:0] burst_addr_o;
  logic [1:0]        beat_o;
  logic              last_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [ADDR_W-1:0] m_start = '0;
  logic              m_mode  = 1'b0;
  logic [1:0]        m_beat  = '0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load_i),
    .adv_i        (adv_i),
    .mode_i       (mode_i),
    .start_addr_i (start_addr_i),
    .burst_addr_o (burst_addr_o),
    .beat_o       (beat_o),
    .last_o       (last_o)
  );

  function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] b, logic m);
    return m ? (s ^ b) : 2'(s + b);
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr();
    return {m_start[ADDR_W-1:2], exp_low(m_start[1:0], m_beat, m_mode)};
  endfunction

  task automatic check(input string tag);
    logic [ADDR_W-1:0] ea;
    ea = exp_addr();
    checks++;
    if (burst_addr_o !== ea || beat_o !== m_beat || last_o !== (m_beat == 2'd3)) begin
      errors++;
      $display("FAIL %s addr=%h beat=%0d last=%0b expected addr=%h beat=%0d last=%0b",
               tag, burst_addr_o, beat_o, last_o, ea, m_beat, (m_beat == 2'd3));
    end
  endtask

  task automatic step(input logic l, input logic a, input logic m,
                      input logic [ADDR_W-1:0] s, input string tag);
    @(negedge clk);
    load_i = l; adv_i = a; mode_i = m; start_addr_i = s;
    @(posedge clk);
    #1;
    if (rst) begin
      m_start = '0; m_mode = 1'b0; m_beat = '0;
    end else if (l) begin
      m_start = s; m_mode = m; m_beat = '0;
    end else if (a) begin
      m_beat = m_beat + 2'd1;
    end
    #1;
    check(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset clears state
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, "R1");
    step(1'b0, 1'b0, 1'b0, 32'h0, "R1");
    rst = 1'b0;

    // R2 load, R3 linear from 01, wrap R6, last R10
    step(1'b1, 1'b0, 1'b0, 32'hABCD_0001, "R2");
    step(1'b0, 1'b1, 1'b0, 32'h0, "R3");
    step(1'b0, 1'b1, 1'b0, 32'h0, "R3");
    step(1'b0, 1'b1, 1'b0, 32'h0, "R10");
    if (burst_addr_o[1:0] !== 2'b00) begin
      errors++;
      $display("FAIL R3 low=%b expected 00", burst_addr_o[1:0]);
    end
    checks++;
    step(1'b0, 1'b1, 1'b0, 32'h0, "R6");

    // R4 interleaved for each start value
    for (int s = 0; s < 4; s++) begin
      step(1'b1, 1'b0, 1'b1, 32'h1234_5670 | s, "R4");
      for (int b = 0; b < 4; b++) step(1'b0, 1'b1, 1'b1, 32'h0, "R4");
    end
    step(1'b1, 1'b0, 1'b1, 32'h0000_0001, "R4");
    step(1'b0, 1'b1, 1'b1, 32'h0, "R4");
    checks++;
    if (burst_addr_o[1:0] !== 2'b00) begin
      errors++;
      $display("FAIL R4 low=%b expected 00", burst_addr_o[1:0]);
    end

    // R7 hold with no strobes, R5 upper ignores input
    step(1'b0, 1'b1, 1'b0, 32'h0, "R7");
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF, "R7");
    step(1'b0, 1'b1, 1'b0, 32'h5555_5555, "R5");

    // R8 load beats advance
    step(1'b0, 1'b1, 1'b0, 32'h0, "R8");
    step(1'b1, 1'b1, 1'b0, 32'h0F0F_0F02, "R8");

    // R9 mode change between loads ignored
    step(1'b1, 1'b0, 1'b0, 32'h0000_0003, "R9");
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'(k % 2 == 0), 32'h0, "R9");
    step(1'b1, 1'b0, 1'b1, 32'h0000_0002, "R9");
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b0, 32'h0, "R9");

    // Random mix
    for (int k = 0; k < 400; k++) begin
      step(($urandom % 6) == 0, ($urandom % 3) != 0, 1'($urandom), $urandom, "RND");
    end

    // R1 reset again mid-burst
    rst = 1'b1;
    step(1'b0, 1'b1, 1'b1, 32'h0, "R1");
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b0, 32'h0, "R1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule